// File: doc/BRIEF.md
# Synchronous Presettable Binary Counter Stage

This block is one stage of an up counter that wraps through every value of its state width (sixteen states by default). It is presettable. While the active-low parallel-load line is low, a rising clock edge copies the data input into the state. While the load line is high and both count enables are high, the edge adds one. Otherwise the state holds. An active-low clear acts at once, without waiting for the clock, and overrides every other input.

The two enables do different jobs. The local enable gates counting only. The chain enable gates counting and also qualifies the carry flag. The carry flag is high when the chain enable is high and the state is all ones. It is decoded combinationally from the current state, so it is valid in the same cycle.

To build a wider counter, feed one stage's carry into the next stage's chain enable. That gives ripple-style chaining. For look-ahead chaining, fan the first stage's carry out to the local enables of the later stages. All control and data pins are plain levels sampled on the clock edge. There is no handshake, because the stage neither accepts nor produces a data stream.

Top module: `sync_load_counter`

## Requirements
- R1: While `clr_n` is low, `q` is zero and `carry` is low, with no clock edge needed. The clear takes effect between clock edges.
- R2: A count from the all-ones state (15 at width 4) gives zero on the next rising edge.
- R3: Precedence, highest first: clear, then load, then count, then hold. Holding `clr_n` low across an edge with `load_n` low keeps `q` at zero.
- R4: When `clr_n` is high and `load_n` is low, the next rising edge stores `din` into `q`, whatever `en_local` and `en_chain` are.
- R5: When `clr_n`, `load_n`, `en_local` and `en_chain` are all high, the next rising edge raises `q` by one.
- R6: When `clr_n` and `load_n` are high and either enable is low, `q` keeps its value across the edge.
- R7: `carry` is high exactly when `en_chain` is high and `q` is all ones. It follows those signals in the same cycle, and `en_local` has no effect on it.
- R8: Two stages, with the first stage's `carry` driving the second stage's `en_chain`, count together from 0 through 255 and wrap to 0. The high stage forms bits 7:4 of the combined value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_local | input | 1 | Count enable that gates counting only |
| en_chain | input | 1 | Count enable that also qualifies `carry` |
| din | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Counter state |
| carry | output | 1 | Terminal-count flag for chaining |

## Verification
The bench builds the stage with the default WIDTH of 4. With that width the all-ones wrap and every precedence combination are reached within a few cycles from a preset. A second 4-bit instance is chained behind the first through the chain enable. That makes an 8-bit counter whose full 0 to 255 cycle, with the carry propagating across the stage boundary and the final wrap, completes in 256 clocks.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } mode_t;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cnt_pkg::*;
(
  input  logic  load_n,
  input  logic  en_local,
  input  logic  en_chain,
  output mode_t mode
);
  // Load outranks counting; counting needs both enables.
  always_comb begin
    if (!load_n)                  mode = MODE_LOAD;
    else if (en_local && en_chain) mode = MODE_COUNT;
    else                          mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_t            mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] toggle;
  logic [WIDTH-1:0] incr;

  // Toggle chain: bit i flips when all lower bits are one.
  assign toggle[0] = 1'b1;
  genvar i;
  generate
    for (i = 1; i < WIDTH; i++) begin : g_tgl
      assign toggle[i] = toggle[i-1] & cur[i-1];
    end
    for (i = 0; i < WIDTH; i++) begin : g_inc
      assign incr[i] = cur[i] ^ toggle[i];
    end
  endgenerate

  always_comb begin
    case (mode)
      MODE_LOAD:  nxt = din;
      MODE_COUNT: nxt = incr;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_carry_gen.sv
module cnt_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_chain,
  output logic             carry
);
  assign carry = en_chain & (&cur);
endmodule

// File: rtl/sync_load_counter.sv
module sync_load_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_local,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  mode_t            mode;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  cnt_mode_sel u_mode (
    .load_n   (load_n),
    .en_local (en_local),
    .en_chain (en_chain),
    .mode     (mode)
  );

  cnt_next_state #(.WIDTH(WIDTH)) u_next (
    .mode (mode),
    .cur  (state_q),
    .din  (din),
    .nxt  (state_d)
  );

  cnt_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .cur      (state_q),
    .en_chain (en_chain),
    .carry    (carry)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign q = state_q;

  // R4
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_local && en_chain) |=> q == WIDTH'($past(q) + 1'b1));

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_local && en_chain && q == ALL_ONES) |=> q == '0);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_local && en_chain)) |=> $stable(q));

  // R7
  carry_needs_full_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (q == ALL_ONES && en_chain));
endmodule

// File: tb/tb_sync_load_counter.sv
module tb_sync_load_counter;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1, en_local = 1'b0, en_chain = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q, q_hi;
  logic       carry, carry_hi;
  int         errors = 0, checks = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  sync_load_counter #(.WIDTH(4)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_local(en_local),
    .en_chain(en_chain), .din(din), .q(q), .carry(carry));

  // High stage: chain enable driven by the low stage carry (R8)
  sync_load_counter #(.WIDTH(4)) dut_hi (
    .clk(clk), .clr_n(clr_n), .load_n(1'b1), .en_local(1'b1),
    .en_chain(carry), .din(4'h0), .q(q_hi), .carry(carry_hi));

  // {load_n, en_local, en_chain, din, exp_q, exp_carry}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'hE, 4'hE, 1'b0},  // R4 load, enables low
    {1'b1, 1'b1, 1'b1, 4'h0, 4'hF, 1'b1},  // R5 count, R7 carry
    {1'b1, 1'b0, 1'b1, 4'h0, 4'hF, 1'b1},  // R6 hold, R7 en_local no effect
    {1'b1, 1'b1, 1'b0, 4'h0, 4'hF, 1'b0},  // R6 hold, R7 gated
    {1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0},  // R2 wrap
    {1'b0, 1'b1, 1'b1, 4'h5, 4'h5, 1'b0},  // R3 load over count
    {1'b1, 1'b1, 1'b1, 4'h9, 4'h6, 1'b0},  // R5
    {1'b1, 1'b0, 1'b0, 4'h2, 4'h6, 1'b0},  // R6
    {1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1},  // R4, R7
    {1'b1, 1'b1, 1'b1, 4'h7, 4'h0, 1'b0},  // R2
    {1'b0, 1'b0, 1'b0, 4'h3, 4'h3, 1'b0},  // R4
    {1'b1, 1'b1, 1'b1, 4'h0, 4'h4, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    // Reset state
    #12;
    en_chain = 1'b1;
    check("R1 reset q", 32'(q), 32'h0);
    check("R1 reset carry", 32'(carry), 32'h0);
    @(posedge clk); #2;
    clr_n = 1'b1;

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      {load_n, en_local, en_chain, din} = VEC[i][11:5];
      @(posedge clk); #2;
      check($sformatf("R4/R5/R6/R2 vec%0d q", i), 32'(q), 32'(VEC[i][4:1]));
      check($sformatf("R7 vec%0d carry", i), 32'(carry), 32'(VEC[i][0]));
    end

    // R7: same-cycle carry response without a clock edge
    load_n = 1'b0; din = 4'hF; en_local = 1'b0; en_chain = 1'b0;
    @(posedge clk); #2;
    load_n = 1'b1;
    check("R7 carry low with chain off", 32'(carry), 32'h0);
    en_chain = 1'b1; #1;
    check("R7 carry same cycle", 32'(carry), 32'h1);

    // R1: asynchronous clear between edges
    #1; clr_n = 1'b0; #1;
    check("R1 async clear q", 32'(q), 32'h0);
    check("R1 async clear carry", 32'(carry), 32'h0);

    // R3: clear outranks load across an edge
    load_n = 1'b0; din = 4'hA;
    @(posedge clk); #2;
    check("R3 clear over load", 32'(q), 32'h0);
    load_n = 1'b1;
    clr_n = 1'b1;

    // R8: two-stage chain counts 0..255 and wraps
    en_local = 1'b1; en_chain = 1'b1;
    for (int n = 1; n <= 256; n++) begin
      @(posedge clk); #2;
      check("R8 chain value", 32'({q_hi, q}), 32'(n % 256));
    end

    finished = 1'b1;
    finish_run();
  end
endmodule